// File: doc/BRIEF.md
# Block Memory Request Responder

This block sits on the memory side of a block-oriented request/response protocol and serves uncached reads, writes, atomics and prefetches from a small internal store. The store is organised as blocks, and each block holds several data beats. A requester offers typed request beats on a ready/valid request channel. The block decodes the request kind, touches the store and answers on a ready/valid response channel with a typed response. Each response carries the requester's transaction id and a manager tag. The requester closes each transaction by returning that tag on a completion channel.

Only one transaction is in flight at a time. From the moment the final request beat is taken until a completion with the matching tag arrives, the request channel is closed. Single-beat writes, block writes and atomics carry data. Only block writes span several request beats, and only block-read responses span several response beats. An atomic answers with the beat as it stood before the operation and stores the updated operand in the same transaction. The auxiliary field of every request carries an allocation hint in its lowest bit. The block treats this hint as advice only.

Top module: `blkmem_responder`

## Requirements
- R1: The request kind on `req_kind` is decoded as 000 beat read, 001 block read, 010 beat write, 011 block write, 100 atomic, 101 prefetch. The response kind on `rsp_kind` is 100 for a beat read and for an atomic, 101 for a block read, 011 for both kinds of write, and 001 for a prefetch. Code 000 is reserved for writeback acknowledges and is never sent. Responses of kind 011 and 001 carry zero data and beat index 0.
- R2: A beat read returns the stored beat at word address {`req_block`, `req_beat`} in a single response whose `rsp_beat` equals `req_beat`.
- R3: A block read returns every beat of the block in one response each, with `rsp_beat` counting 0 to BEATS-1. Under backpressure the offered beat and all response fields hold steady, and no beat is dropped or repeated.
- R4: A beat write updates only the bytes whose bit is set in the write mask `req_aux[LANES:1]`. Bit i of the mask covers data bits 8i+7..8i.
- R5: A block write takes BEATS consecutive accepted request beats. These are stored to beats 0..BEATS-1 of the block in arrival order, and `req_beat` is ignored. Each beat applies its own mask from `req_aux[LANES:1]`. A single acknowledge follows the last beat.
- R6: An atomic takes its opcode from `req_aux[3:1]`: 0 swap, 1 add, 2 xor, 3 and, 4 signed min, 5 signed max, 6 unsigned min, 7 unsigned max. The operand size comes from `req_aux[5:4]` (0 byte, 1 half, 2 word, 3 double) and the byte offset within the beat from `req_aux[8:6]`. The full byte address is therefore {block, beat, offset}. The operand sits in `req_wdata` on the same byte lanes. The response returns the prior beat, and only the operand's bytes are rewritten; an add carries nothing past the operand width.
- R7: The min and max operations compare at the operand width. The signed forms treat the top bit of the operand as its sign, and the unsigned forms do not.
- R8: Every response beat carries the `req_txid` of its request and the current manager tag. The tag is 0 after reset and advances by one, wrapping, at each accepted matching completion.
- R9: `req_ready` is low from the final request beat until a completion with `cmp_mtag` equal to the response's tag is accepted. A completion with any other tag is taken and has no effect. `cmp_ready` is high only while a completion is awaited.
- R10: The allocation hint `req_aux[0]` changes neither responses nor stored data.
- R11: After reset `req_ready` is high, `rsp_valid` and `cmp_ready` are low, and every stored beat reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request beat offered |
| req_ready | output | 1 | Request beat can be taken |
| req_kind | input | 3 | Request kind code |
| req_txid | input | XID_W | Requester transaction id |
| req_block | input | log2(BLOCKS) | Block address |
| req_beat | input | log2(BEATS) | Beat index within block |
| req_wdata | input | DATA_W | Write data or atomic operand |
| req_aux | input | DATA_W/8+1 | Hint bit, write mask or atomic fields |
| rsp_valid | output | 1 | Response beat offered |
| rsp_ready | input | 1 | Response beat taken |
| rsp_kind | output | 3 | Response kind code |
| rsp_txid | output | XID_W | Echoed requester id |
| rsp_mtag | output | MID_W | Manager tag |
| rsp_beat | output | log2(BEATS) | Response beat index |
| rsp_rdata | output | DATA_W | Read or prior data |
| cmp_valid | input | 1 | Completion offered |
| cmp_ready | output | 1 | Completion can be taken |
| cmp_mtag | input | MID_W | Tag being completed |

## Verification
Some properties are checked on every cycle. The request channel stays closed while a response is offered, and a response holds steady under backpressure. Block-read beat indices step by one, only legal response kinds appear, and acknowledges carry zero payload. The completion wait must follow the final response beat. Stored contents cannot be seen by a property, so only the bench's scenarios can show them: masked and block writes, every atomic opcode at several sizes and offsets, signed against unsigned ordering, and the hint having no effect. The scenarios also cover rejection of a wrong completion tag and tag wrap-around.

// File: rtl/blkmem_pkg.sv
package blkmem_pkg;

    typedef enum logic [2:0] {
        REQ_GET      = 3'b000,
        REQ_GET_BLK  = 3'b001,
        REQ_PUT      = 3'b010,
        REQ_PUT_BLK  = 3'b011,
        REQ_AMO      = 3'b100,
        REQ_PREFETCH = 3'b101
    } req_kind_e;

    typedef enum logic [2:0] {
        RSP_WB_ACK  = 3'b000,
        RSP_PF_ACK  = 3'b001,
        RSP_PUT_ACK = 3'b011,
        RSP_BEAT    = 3'b100,
        RSP_BLOCK   = 3'b101
    } rsp_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PUTB  = 2'd1,
        PH_RESP  = 2'd2,
        PH_WAIT  = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        AMO_SWAP = 3'd0,
        AMO_ADD  = 3'd1,
        AMO_XOR  = 3'd2,
        AMO_AND  = 3'd3,
        AMO_MIN  = 3'd4,
        AMO_MAX  = 3'd5,
        AMO_MINU = 3'd6,
        AMO_MAXU = 3'd7
    } amo_op_e;

endpackage

// File: rtl/blkmem_amo_alu.sv
// Sub-word atomic datapath: isolates the operand lanes of the prior beat and
// of the request data, combines them, and returns lane-aligned data plus a
// byte-enable covering exactly the operand bytes.
module blkmem_amo_alu
    import blkmem_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]             old_beat,
    input  logic [DATA_W-1:0]             opnd_beat,
    input  logic [2:0]                    op,
    input  logic [1:0]                    size,
    input  logic [$clog2(DATA_W/8)-1:0]   off,
    output logic [DATA_W-1:0]             wdata,
    output logic [DATA_W/8-1:0]           wmask
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int SH_W  = OFF_W + 3;

    logic [SH_W-1:0]   sh;
    logic [DATA_W-1:0] szmask, sbit, a, b, res;
    logic              lt_s, lt_u;

    always_comb begin
        sh = {off, 3'b000};
        case (size)
            2'd0:    szmask = DATA_W'(64'h0000_0000_0000_00FF);
            2'd1:    szmask = DATA_W'(64'h0000_0000_0000_FFFF);
            2'd2:    szmask = DATA_W'(64'h0000_0000_FFFF_FFFF);
            default: szmask = '1;
        endcase
        sbit = szmask ^ (szmask >> 1);
        a    = (old_beat  >> sh) & szmask;
        b    = (opnd_beat >> sh) & szmask;
        lt_u = a < b;
        lt_s = (a ^ sbit) < (b ^ sbit);
        case (op)
            AMO_SWAP: res = b;
            AMO_ADD:  res = a + b;
            AMO_XOR:  res = a ^ b;
            AMO_AND:  res = a & b;
            AMO_MIN:  res = lt_s ? a : b;
            AMO_MAX:  res = lt_s ? b : a;
            AMO_MINU: res = lt_u ? a : b;
            default:  res = lt_u ? b : a;
        endcase
        wdata = (res & szmask) << sh;
        wmask = ((LANES'(1) << (1 << size)) - LANES'(1)) << off;
    end

endmodule

// File: rtl/blkmem_store.sv
// Beat-wide storage with one byte-masked write port and one combinational
// read port, cleared by reset.
module blkmem_store #(
    parameter int WORDS  = 32,
    parameter int DATA_W = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [$clog2(WORDS)-1:0]   waddr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [DATA_W/8-1:0]        wmask,
    input  logic [$clog2(WORDS)-1:0]   raddr,
    output logic [DATA_W-1:0]          rdata
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
        end else if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (wmask[l]) mem_q[waddr][8*l +: 8] <= wdata[8*l +: 8];
            end
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/blkmem_responder.sv
// Request/response sequencer: one transaction in flight, typed responses,
// block streaming and completion-tag gating.
module blkmem_responder
    import blkmem_pkg::*;
#(
    parameter int BLOCKS = 8,
    parameter int BEATS  = 4,
    parameter int DATA_W = 64,
    parameter int XID_W  = 4,
    parameter int MID_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [2:0]                 req_kind,
    input  logic [XID_W-1:0]           req_txid,
    input  logic [$clog2(BLOCKS)-1:0]  req_block,
    input  logic [$clog2(BEATS)-1:0]   req_beat,
    input  logic [DATA_W-1:0]          req_wdata,
    input  logic [DATA_W/8:0]          req_aux,
    output logic                       rsp_valid,
    input  logic                       rsp_ready,
    output logic [2:0]                 rsp_kind,
    output logic [XID_W-1:0]           rsp_txid,
    output logic [MID_W-1:0]           rsp_mtag,
    output logic [$clog2(BEATS)-1:0]   rsp_beat,
    output logic [DATA_W-1:0]          rsp_rdata,
    input  logic                       cmp_valid,
    output logic                       cmp_ready,
    input  logic [MID_W-1:0]           cmp_mtag
);
    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);
    localparam int BLK_W  = $clog2(BLOCKS);
    localparam int BEAT_W = $clog2(BEATS);
    localparam int WORDS  = BLOCKS * BEATS;
    localparam int ADDR_W = BLK_W + BEAT_W;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    typedef struct packed {
        phase_e              phase;
        logic [XID_W-1:0]    txid;
        logic [BLK_W-1:0]    blk;
        logic [BEAT_W-1:0]   beat;
        logic [BEAT_W-1:0]   cnt;
        rsp_kind_e           kind;
        logic [MID_W-1:0]    mtag;
        logic [DATA_W-1:0]   data;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic                mem_we;
    logic [ADDR_W-1:0]   mem_waddr, mem_raddr;
    logic [DATA_W-1:0]   mem_wdata, mem_rdata;
    logic [LANES-1:0]    mem_wmask;
    logic [DATA_W-1:0]   amo_wdata;
    logic [LANES-1:0]    amo_wmask;
    logic                hint_unused;

    assign hint_unused = req_aux[0];

    blkmem_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .wmask (mem_wmask),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    blkmem_amo_alu #(.DATA_W(DATA_W)) u_amo (
        .old_beat  (mem_rdata),
        .opnd_beat (req_wdata),
        .op        (req_aux[3:1]),
        .size      (req_aux[5:4]),
        .off       (req_aux[6 +: OFF_W]),
        .wdata     (amo_wdata),
        .wmask     (amo_wmask)
    );

    always_comb begin
        ctx_d     = ctx_q;
        mem_we    = 1'b0;
        mem_waddr = {req_block, req_beat};
        mem_wdata = req_wdata;
        mem_wmask = req_aux[LANES:1];
        mem_raddr = (ctx_q.phase == PH_RESP) ? {ctx_q.blk, ctx_q.cnt}
                                             : {req_block, req_beat};
        req_ready = (ctx_q.phase == PH_IDLE) || (ctx_q.phase == PH_PUTB);
        cmp_ready = (ctx_q.phase == PH_WAIT);
        rsp_valid = (ctx_q.phase == PH_RESP);

        case (ctx_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    ctx_d.txid  = req_txid;
                    ctx_d.blk   = req_block;
                    ctx_d.beat  = req_beat;
                    ctx_d.cnt   = '0;
                    ctx_d.data  = '0;
                    ctx_d.phase = PH_RESP;
                    case (req_kind)
                        REQ_GET: begin
                            ctx_d.kind = RSP_BEAT;
                            ctx_d.data = mem_rdata;
                        end
                        REQ_GET_BLK: ctx_d.kind = RSP_BLOCK;
                        REQ_PUT: begin
                            mem_we     = 1'b1;
                            ctx_d.kind = RSP_PUT_ACK;
                        end
                        REQ_PUT_BLK: begin
                            mem_we      = 1'b1;
                            mem_waddr   = {req_block, {BEAT_W{1'b0}}};
                            ctx_d.cnt   = BEAT_W'(1);
                            ctx_d.kind  = RSP_PUT_ACK;
                            ctx_d.phase = PH_PUTB;
                        end
                        REQ_AMO: begin
                            mem_we     = 1'b1;
                            mem_wdata  = amo_wdata;
                            mem_wmask  = amo_wmask;
                            ctx_d.kind = RSP_BEAT;
                            ctx_d.data = mem_rdata;
                        end
                        default: ctx_d.kind = RSP_PF_ACK;
                    endcase
                end
            end
            PH_PUTB: begin
                if (req_valid) begin
                    mem_we    = 1'b1;
                    mem_waddr = {ctx_q.blk, ctx_q.cnt};
                    if (ctx_q.cnt == LAST_BEAT) begin
                        ctx_d.cnt   = '0;
                        ctx_d.phase = PH_RESP;
                    end else begin
                        ctx_d.cnt = ctx_q.cnt + BEAT_W'(1);
                    end
                end
            end
            PH_RESP: begin
                if (rsp_ready) begin
                    if (ctx_q.kind == RSP_BLOCK && ctx_q.cnt != LAST_BEAT)
                        ctx_d.cnt = ctx_q.cnt + BEAT_W'(1);
                    else
                        ctx_d.phase = PH_WAIT;
                end
            end
            default: begin
                if (cmp_valid && cmp_mtag == ctx_q.mtag) begin
                    ctx_d.phase = PH_IDLE;
                    ctx_d.mtag  = ctx_q.mtag + MID_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign rsp_kind  = ctx_q.kind;
    assign rsp_txid  = ctx_q.txid;
    assign rsp_mtag  = ctx_q.mtag;
    assign rsp_beat  = (ctx_q.kind == RSP_BLOCK) ? ctx_q.cnt
                     : (ctx_q.kind == RSP_BEAT)  ? ctx_q.beat : '0;
    assign rsp_rdata = (ctx_q.kind == RSP_BLOCK) ? mem_rdata : ctx_q.data;

endmodule

// File: rtl/blkmem_responder_chk.sv
module blkmem_responder_chk #(
    parameter int BEATS  = 4,
    parameter int DATA_W = 64,
    parameter int XID_W  = 4,
    parameter int MID_W  = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_ready,
    input logic                      rsp_valid,
    input logic                      rsp_ready,
    input logic [2:0]                rsp_kind,
    input logic [XID_W-1:0]          rsp_txid,
    input logic [MID_W-1:0]          rsp_mtag,
    input logic [$clog2(BEATS)-1:0]  rsp_beat,
    input logic [DATA_W-1:0]         rsp_rdata,
    input logic                      cmp_ready
);
    localparam logic [$clog2(BEATS)-1:0] LAST = $clog2(BEATS)'(BEATS - 1);

    assert_legal_kind_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_kind inside {3'b001, 3'b011, 3'b100, 3'b101}));

    assert_ack_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_kind == 3'b001 || rsp_kind == 3'b011))
        |-> (rsp_rdata == '0 && rsp_beat == '0));

    assert_hold_under_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_kind) && $stable(rsp_beat)
            && $stable(rsp_rdata) && $stable(rsp_txid) && $stable(rsp_mtag)));

    assert_beat_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready && rsp_kind == 3'b101 && rsp_beat != LAST)
        |=> (rsp_valid && rsp_kind == 3'b101 && rsp_beat == $past(rsp_beat) + 1'b1));

    assert_closed_while_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!req_ready && !cmp_ready));

    assert_wait_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready && (rsp_kind != 3'b101 || rsp_beat == LAST))
        |=> (cmp_ready && !rsp_valid && !req_ready));

endmodule

bind blkmem_responder blkmem_responder_chk #(
    .BEATS(BEATS), .DATA_W(DATA_W), .XID_W(XID_W), .MID_W(MID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_kind  (rsp_kind),
    .rsp_txid  (rsp_txid),
    .rsp_mtag  (rsp_mtag),
    .rsp_beat  (rsp_beat),
    .rsp_rdata (rsp_rdata),
    .cmp_ready (cmp_ready)
);

// File: tb/test_blkmem_responder.sv
`timescale 1ns/1ps
module test_blkmem_responder;
    localparam int BLOCKS = 8;
    localparam int BEATS  = 4;
    localparam int DATA_W = 64;
    localparam int XID_W  = 4;
    localparam int MID_W  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [2:0] req_kind = '0;
    logic [XID_W-1:0] req_txid = '0;
    logic [2:0] req_block = '0;
    logic [1:0] req_beat = '0;
    logic [63:0] req_wdata = '0;
    logic [8:0] req_aux = '0;
    logic rsp_valid;
    logic rsp_ready = 1'b0;
    logic [2:0] rsp_kind;
    logic [XID_W-1:0] rsp_txid;
    logic [MID_W-1:0] rsp_mtag;
    logic [1:0] rsp_beat;
    logic [63:0] rsp_rdata;
    logic cmp_valid = 1'b0;
    logic cmp_ready;
    logic [MID_W-1:0] cmp_mtag = '0;

    always #10 clk = ~clk;

    blkmem_responder #(.BLOCKS(BLOCKS), .BEATS(BEATS), .DATA_W(DATA_W),
                       .XID_W(XID_W), .MID_W(MID_W)) i_blkmem_responder (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_txid(req_txid), .req_block(req_block), .req_beat(req_beat),
        .req_wdata(req_wdata), .req_aux(req_aux),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
        .rsp_txid(rsp_txid), .rsp_mtag(rsp_mtag), .rsp_beat(rsp_beat),
        .rsp_rdata(rsp_rdata),
        .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_mtag(cmp_mtag)
    );

    typedef struct {
        logic [2:0]       kind;
        logic [XID_W-1:0] txid;
        logic [MID_W-1:0] mtag;
        logic [1:0]       beat;
        logic [63:0]      data;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    logic [63:0] model [BLOCKS*BEATS];
    int n_cmp = 0;
    int n_bad = 0;
    logic [MID_W-1:0] mid_exp = '0;
    logic [XID_W-1:0] cur_xid = 4'd3;
    bit bp_on = 1'b0;
    logic [7:0] lfsr = 8'h5A;

    // Monitor: decides ready, then compares any beat that will be taken at the next edge.
    always @(negedge clk) begin
        logic rdy;
        exp_t e;
        if (bp_on) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            rdy = lfsr[0];
        end else begin
            rdy = 1'b1;
        end
        rsp_ready = rdy;
        if (rst_n && rsp_valid && rdy) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R1 unexpected response actual kind=%b expected=none", rsp_kind);
            end else begin
                e = exp_q.pop_front();
                if (rsp_kind !== e.kind || rsp_beat !== e.beat || rsp_rdata !== e.data) begin
                    n_bad++;
                    $display("FAIL %s actual kind=%b beat=%0d data=%h expected kind=%b beat=%0d data=%h",
                             e.tag, rsp_kind, rsp_beat, rsp_rdata, e.kind, e.beat, e.data);
                end else if (rsp_txid !== e.txid || rsp_mtag !== e.mtag) begin
                    n_bad++;
                    $display("FAIL R8 actual txid=%h mtag=%h expected txid=%h mtag=%h",
                             rsp_txid, rsp_mtag, e.txid, e.mtag);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] kind, input logic [1:0] beat,
                        input logic [63:0] data, input string tag);
        exp_t e;
        e.kind = kind; e.txid = cur_xid; e.mtag = mid_exp;
        e.beat = beat; e.data = data; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic send_beat(input logic [2:0] kind, input logic [2:0] blk, input logic [1:0] beat,
                             input logic [63:0] data, input logic [8:0] aux);
        req_valid = 1'b1; req_kind = kind; req_txid = cur_xid; req_block = blk;
        req_beat = beat; req_wdata = data; req_aux = aux;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_cmp(input logic [MID_W-1:0] m);
        cmp_valid = 1'b1; cmp_mtag = m;
        while (!cmp_ready) @(negedge clk);
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic close_txn();
        while (exp_q.size() != 0) @(negedge clk);
        send_cmp(mid_exp);
        mid_exp = mid_exp + 1'b1;
        cur_xid = cur_xid + 1'b1;
    endtask

    function automatic logic [63:0] amo_model(input logic [63:0] old, input logic [63:0] opnd,
                                              input logic [2:0] op, input logic [1:0] sz,
                                              input logic [2:0] off);
        int nb = 1 << sz;
        logic [63:0] a = '0, b = '0, r, nw;
        logic lt_s, lt_u;
        for (int i = 0; i < nb; i++) begin
            a[8*i +: 8] = old[8*(off+i) +: 8];
            b[8*i +: 8] = opnd[8*(off+i) +: 8];
        end
        case (sz)
            2'd0: lt_s = $signed(a[7:0])  < $signed(b[7:0]);
            2'd1: lt_s = $signed(a[15:0]) < $signed(b[15:0]);
            2'd2: lt_s = $signed(a[31:0]) < $signed(b[31:0]);
            default: lt_s = $signed(a) < $signed(b);
        endcase
        lt_u = a < b;
        case (op)
            3'd0: r = b;
            3'd1: r = a + b;
            3'd2: r = a ^ b;
            3'd3: r = a & b;
            3'd4: r = lt_s ? a : b;
            3'd5: r = lt_s ? b : a;
            3'd6: r = lt_u ? a : b;
            default: r = lt_u ? b : a;
        endcase
        nw = old;
        for (int i = 0; i < nb; i++) nw[8*(off+i) +: 8] = r[8*i +: 8];
        return nw;
    endfunction

    function automatic logic [8:0] amo_aux(input logic [2:0] op, input logic [1:0] sz, input logic [2:0] off);
        return {off, sz, op, 1'b0};
    endfunction

    task automatic do_req(input logic [2:0] kind, input logic [2:0] blk, input logic [1:0] beat,
                          input logic [63:0] data, input logic [8:0] aux, input string tag);
        int idx = int'(blk) * BEATS + int'(beat);
        case (kind)
            3'b000: push(3'b100, beat, model[idx], tag);
            3'b001: for (int k = 0; k < BEATS; k++)
                        push(3'b101, 2'(k), model[int'(blk)*BEATS + k], tag);
            3'b010: begin
                push(3'b011, 2'd0, 64'd0, tag);
                for (int l = 0; l < 8; l++)
                    if (aux[l+1]) model[idx][8*l +: 8] = data[8*l +: 8];
            end
            3'b100: begin
                push(3'b100, beat, model[idx], tag);
                model[idx] = amo_model(model[idx], data, aux[3:1], aux[5:4], aux[8:6]);
            end
            default: push(3'b001, 2'd0, 64'd0, tag);
        endcase
        send_beat(kind, blk, beat, data, aux);
        close_txn();
    endtask

    task automatic do_putb(input logic [2:0] blk, input logic [63:0] d [4], input logic [7:0] m [4],
                           input logic hint, input string tag);
        push(3'b011, 2'd0, 64'd0, tag);
        for (int k = 0; k < BEATS; k++) begin
            for (int l = 0; l < 8; l++)
                if (m[k][l]) model[int'(blk)*BEATS + k][8*l +: 8] = d[k][8*l +: 8];
            send_beat(3'b011, blk, 2'd0, d[k], {m[k], hint});
        end
        close_txn();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] bd [4];
        logic [7:0]  bm [4];
        for (int i = 0; i < BLOCKS*BEATS; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(req_ready === 1'b1, "R11 req_ready", {63'd0, req_ready}, 64'd1);
        chk(rsp_valid === 1'b0, "R11 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        chk(cmp_ready === 1'b0, "R11 cmp_ready", {63'd0, cmp_ready}, 64'd0);

        do_req(3'b000, 3'd2, 2'd1, 64'd0, 9'd0, "R11 R2 zero read");
        do_req(3'b001, 3'd0, 2'd0, 64'd0, 9'd0, "R11 R3 zero block");

        // R4 R10: masked writes, hint set and clear
        do_req(3'b010, 3'd2, 2'd1, 64'h1122_3344_5566_7788, {8'hFF, 1'b1}, "R1 R4 R10 put ack");
        do_req(3'b000, 3'd2, 2'd1, 64'd0, 9'd1, "R2 R10 read back");
        do_req(3'b010, 3'd2, 2'd1, 64'hAAAA_AAAA_AAAA_AAAA, {8'h0F, 1'b0}, "R4 put ack");
        do_req(3'b000, 3'd2, 2'd1, 64'd0, 9'd0, "R4 low half mask");
        do_req(3'b010, 3'd5, 2'd3, 64'hCAFE_F00D_DEAD_BEEF, {8'b1010_0101, 1'b1}, "R4 put ack");
        do_req(3'b000, 3'd5, 2'd3, 64'd0, 9'd0, "R4 sparse mask");

        // R5: block write with per-beat masks, then streamed read under backpressure (R3)
        bd[0] = 64'h0101_0101_0101_0101; bm[0] = 8'hFF;
        bd[1] = 64'h0202_0202_0202_0202; bm[1] = 8'hF0;
        bd[2] = 64'h0303_0303_0303_0303; bm[2] = 8'h01;
        bd[3] = 64'h0404_0404_0404_0404; bm[3] = 8'hFF;
        do_putb(3'd3, bd, bm, 1'b1, "R5 R10 block put ack");
        bp_on = 1'b1;
        do_req(3'b001, 3'd3, 2'd2, 64'd0, 9'd0, "R3 R5 block read stalled");
        do_req(3'b001, 3'd2, 2'd0, 64'd0, 9'd1, "R3 block read stalled");
        bp_on = 1'b0;

        // R6 R7: atomics on block 6 beat 2
        do_req(3'b010, 3'd6, 2'd2, 64'h8000_0001_7FFF_FF80, {8'hFF, 1'b0}, "R6 base put");
        do_req(3'b100, 3'd6, 2'd2, 64'h0000_0003_0000_0000, amo_aux(3'd1, 2'd2, 3'd4), "R6 add word");
        do_req(3'b100, 3'd6, 2'd2, 64'h5A00_0000_0000_0000, amo_aux(3'd0, 2'd0, 3'd7), "R6 swap byte");
        do_req(3'b100, 3'd6, 2'd2, 64'h0000_0000_0000_0001, amo_aux(3'd4, 2'd0, 3'd0), "R7 min signed");
        do_req(3'b000, 3'd6, 2'd2, 64'd0, 9'd0, "R7 min signed result");
        do_req(3'b100, 3'd6, 2'd2, 64'h0000_0000_0000_0001, amo_aux(3'd6, 2'd0, 3'd0), "R7 min unsigned");
        do_req(3'b100, 3'd6, 2'd2, 64'h0000_0000_8000_0000, amo_aux(3'd5, 2'd1, 3'd2), "R7 max signed");
        do_req(3'b000, 3'd6, 2'd2, 64'd0, 9'd0, "R7 max signed result");
        do_req(3'b100, 3'd6, 2'd2, 64'h0000_0000_8000_0000, amo_aux(3'd7, 2'd1, 3'd2), "R7 max unsigned");
        do_req(3'b100, 3'd6, 2'd2, 64'h0000_0000_9000_0000, amo_aux(3'd1, 2'd0, 3'd3), "R6 add byte overflow");
        do_req(3'b100, 3'd6, 2'd2, 64'hFFFF_0000_FFFF_0000, amo_aux(3'd2, 2'd3, 3'd0), "R6 xor double");
        do_req(3'b100, 3'd6, 2'd2, 64'hFFFF_FFFF_0F0F_F0F0, amo_aux(3'd3, 2'd2, 3'd0), "R6 and word");
        do_req(3'b000, 3'd6, 2'd2, 64'd0, 9'd0, "R6 final beat");

        // R1 R10: prefetch acknowledges and leaves data untouched
        do_req(3'b101, 3'd6, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 9'h1FF, "R1 R10 prefetch ack");
        do_req(3'b000, 3'd6, 2'd2, 64'd0, 9'd0, "R10 after prefetch");

        // R9: wrong completion tag is ignored
        push(3'b100, 2'd0, model[0], "R9 read");
        send_beat(3'b000, 3'd0, 2'd0, 64'd0, 9'd0);
        while (exp_q.size() != 0) @(negedge clk);
        send_cmp(mid_exp + 1'b1);
        for (int i = 0; i < 3; i++) begin
            chk(req_ready === 1'b0, "R9 closed after wrong tag", {63'd0, req_ready}, 64'd0);
            chk(cmp_ready === 1'b1, "R9 still awaiting tag", {63'd0, cmp_ready}, 64'd1);
            @(negedge clk);
        end
        send_cmp(mid_exp);
        mid_exp = mid_exp + 1'b1;
        cur_xid = cur_xid + 1'b1;
        chk(req_ready === 1'b1, "R9 open after matching tag", {63'd0, req_ready}, 64'd1);
        do_req(3'b000, 3'd3, 2'd3, 64'd0, 9'd0, "R8 R2 after tag reuse");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3 leftover expected beats", 64'(exp_q.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule